// File: doc/BRIEF.md
# Dual-Mode 16-Bit Down Timer

This block is a 16-bit down counter behind a two-address byte-wide register port. Software first places a low byte in a holding latch. It then writes the high byte, which loads the whole counter in one step and arms the timer for a single interrupt. The counter counts down in one of two ways. In interval mode it steps once per system clock. In pulse mode it steps once per falling edge on an asynchronous input pin.

After the armed event the counter is not stopped. It wraps past zero and keeps running while the flag stays quiet, so software can read back how far it has moved since the event. The flag is always visible on its own output. It reaches the active-low interrupt request only when the enable mask input is high. A read of the low byte, or a new write of the high byte, clears the flag.

Top module: `dual_mode_timer`

## Requirements
- R1: A write with `bus_hi`=0 stores `bus_wdata` in the holding latch and leaves the counter unchanged.
- R2: A write with `bus_hi`=1 loads the counter with {`bus_wdata`, latch}, clears `flag` and arms the timer. A load in the same cycle as a decrement takes priority over the decrement.
- R3: `bus_rdata` is combinational. It gives counter bits [7:0] when `bus_hi`=0 and bits [15:8] when `bus_hi`=1. A read strobe with `bus_hi`=0 clears `flag` at that edge. A read with `bus_hi`=1 has no side effect.
- R4: With `mode_pulse`=0 the counter decreases by one at every clock edge that carries no load.
- R5: In interval mode the timeout is the step from 0000h to FFFFh. If the timer is armed, this step sets `flag` and disarms the timer.
- R6: After the one permitted setting, later timeouts leave `flag` at 0 until the high byte is written again. Reset leaves the timer disarmed.
- R7: With `mode_pulse`=1, each falling edge of `ext_pulse` causes exactly one decrement, however long the pin stays low. The decrement takes effect on the third clock edge after the pin falls (two synchroniser flops plus the edge register). Rising edges do nothing. The timeout in this mode is the step from 0001h to 0000h.
- R8: In interval mode `ext_pulse` has no effect on the count. In pulse mode the clock alone does not change the count.
- R9: `irq_n` is 0 exactly when `flag`=1 and `irq_en`=1. `flag` shows the set state regardless of `irq_en`.
- R10: After reset the counter and latch are 0000h/00h, `flag`=0, `irq_n`=1, and the timer is disarmed.
- R11: When a timeout that sets the flag coincides with a low-byte read, the set wins and `flag` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel) |
| bus_hi | input | 1 | Register address: 0 low byte, 1 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed counter byte |
| mode_pulse | input | 1 | 0 interval mode, 1 pulse-counting mode |
| irq_en | input | 1 | Interrupt enable mask |
| ext_pulse | input | 1 | Asynchronous pulse input pin |
| flag | output | 1 | Interrupt flag status |
| irq_n | output | 1 | Active-low masked interrupt request |

## Verification
The hardest case to reach from the ports is the one-shot suppression in interval mode. Seeing it needs a full 65536-cycle wrap after the flag has already been set and cleared. The bench reaches it by clearing the flag with a low-byte read just after the first timeout, then idling through a complete second wrap while it watches `flag` every cycle. In pulse mode the same rule is reached in a few cycles: the bench counts down through zero and then sends one more pulse. The set-versus-clear collision is produced by timing a low-byte read onto the exact edge where the count leaves zero.

// File: rtl/timer_pkg.sv
package timer_pkg;

   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_PULSE    = 1'b1
   } tmr_mode_e;

   typedef struct packed {
      logic wr_lo;
      logic wr_hi;
      logic rd_lo;
      logic rd_hi;
   } tmr_access_t;

   function automatic tmr_access_t decode_access(input logic sel, input logic wr,
                                                 input logic rd, input logic hi);
      tmr_access_t a;
      a.wr_lo = sel & wr & ~hi;
      a.wr_hi = sel & wr & hi;
      a.rd_lo = sel & rd & ~wr & ~hi;
      a.rd_hi = sel & rd & ~wr & hi;
      return a;
   endfunction

endpackage

// File: rtl/tmr_edge_detect.sv
module tmr_edge_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic fall_pulse
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_edge_detect: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= pin_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign fall_pulse = prev_q & ~sync_q[STAGES-1];

   // R7: one step per edge, never on back-to-back cycles
   p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             at_zero,
   output logic             at_one
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (load) count_q <= load_val;
      else if (dec)  count_q <= count_q - ONE;
   end

   assign count   = count_q;
   assign at_zero = (count_q == '0);
   assign at_one  = (count_q == ONE);

   // R2: load wins and lands whole
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));

   // R4: one step down per accepted decrement, wrapping past zero
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && dec) |=> (count == CNT_W'($past(count) - ONE)));

   // R8: no load, no decrement, no change
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(count));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic clr,
   input  logic timeout,
   input  logic irq_en,
   output logic flag,
   output logic irq_n
);

   logic armed_q;
   logic flag_q;
   logic fire;

   assign fire = timeout & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    armed_q <= 1'b0;
      else if (arm)  armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (fire)       flag_q <= 1'b1;
      else if (clr || arm) flag_q <= 1'b0;
   end

   assign flag  = flag_q;
   assign irq_n = ~(flag_q & irq_en);

   // R6: flag can only rise from an armed timer
   p_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(armed_q));

   // R5: firing consumes the arming
   p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !arm) |=> !armed_q);

   // R2: a high-byte write leaves the flag clear
   p_arm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !timeout) |=> !flag);

   // R11: a coinciding set beats the read clear
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && clr) |=> flag);

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_hi,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              mode_pulse,
   input  logic              irq_en,
   input  logic              ext_pulse,
   output logic              flag,
   output logic              irq_n
);
   import timer_pkg::*;

   localparam int CNT_W = 2 * DATA_W;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("dual_mode_timer: DATA_W must be at least 2");
   end

   tmr_access_t      acc;
   tmr_mode_e        mode;
   logic [DATA_W-1:0] latch_q;
   logic [CNT_W-1:0] count;
   logic             at_zero;
   logic             at_one;
   logic             fall_pulse;
   logic             step;
   logic             timeout;

   assign acc  = decode_access(bus_sel, bus_wr, bus_rd, bus_hi);
   assign mode = tmr_mode_e'(mode_pulse);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          latch_q <= '0;
      else if (acc.wr_lo)  latch_q <= bus_wdata;
   end

   tmr_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_async  (ext_pulse),
      .fall_pulse (fall_pulse)
   );

   always_comb begin
      unique case (mode)
         MODE_INTERVAL: begin
            step    = 1'b1;
            timeout = at_zero & ~acc.wr_hi;
         end
         MODE_PULSE: begin
            step    = fall_pulse;
            timeout = fall_pulse & at_one & ~acc.wr_hi;
         end
         default: begin
            step    = 1'b0;
            timeout = 1'b0;
         end
      endcase
   end

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc.wr_hi),
      .load_val ({bus_wdata, latch_q}),
      .dec      (step),
      .count    (count),
      .at_zero  (at_zero),
      .at_one   (at_one)
   );

   tmr_irq_ctrl u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (acc.wr_hi),
      .clr     (acc.rd_lo),
      .timeout (timeout),
      .irq_en  (irq_en),
      .flag    (flag),
      .irq_n   (irq_n)
   );

   assign bus_rdata = bus_hi ? count[CNT_W-1:DATA_W] : count[DATA_W-1:0];

   // R1: latch writes never move the count in pulse mode
   p_latch_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.wr_lo && mode_pulse && !fall_pulse) |=> $stable(count));

   // R3: a high-byte read leaves the flag alone
   p_hi_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd_hi && !timeout) |=> $stable(flag));

   // R8: in pulse mode the pin pulse is the only decrement source
   p_pulse_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pulse && !fall_pulse && !acc.wr_hi) |=> $stable(count));

endmodule

// File: tb/dual_mode_timer_tb.sv
`timescale 1ns/1ps
module dual_mode_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_hi = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       mode_pulse = 1'b0, irq_en = 1'b1, ext_pulse = 1'b1;
   logic       flag, irq_n;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   dual_mode_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_hi(bus_hi), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .mode_pulse(mode_pulse), .irq_en(irq_en),
      .ext_pulse(ext_pulse), .flag(flag), .irq_n(irq_n)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard queue
   always begin
      @(negedge clk);
      #2;
      if (bus_sel && bus_rd && !bus_wr) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: read with empty queue actual=%h expected=none", bus_rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({8'h00, bus_rdata}, {8'h00, e}, t);
         end
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic bus_write(input logic hi, input logic [7:0] d);
      bus_sel = 1; bus_wr = 1; bus_hi = hi; bus_wdata = d;
      tick();
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic read_expect(input logic hi, input logic [7:0] e, input string tag);
      bus_sel = 1; bus_rd = 1; bus_hi = hi;
      exp_q.push_back(e); tag_q.push_back(tag);
      tick();
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic pulse();
      ext_pulse = 0;
      repeat (3) tick();
      ext_pulse = 1;
      repeat (3) tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      bit stayed_low;
      repeat (3) tick();
      rst_n = 1;
      // R10: reset state (read before any edge after release)
      check({15'd0, flag}, 16'd0, "R10 flag after reset");
      check({15'd0, irq_n}, 16'd1, "R10 irq_n after reset");
      read_expect(1'b0, 8'h00, "R10 count low after reset");
      // R6/R10: disarmed, counter wrapped from zero, no flag
      read_expect(1'b1, 8'hFF, "R10 wrapped high with timer disarmed");
      check({15'd0, flag}, 16'd0, "R6 no flag when never armed");

      // R4 with pin activity ignored (R8): load 0x0123
      bus_write(1'b0, 8'h23);
      bus_write(1'b1, 8'h01);                 // now at n1, count 0123
      read_expect(1'b0, 8'h23, "R2 loaded low byte");    // n1 -> n2
      for (int i = 0; i < 32; i++) begin
         ext_pulse = i[2];
         tick();
      end
      ext_pulse = 1;                          // at n34, count 0123-33
      read_expect(1'b0, 8'h02, "R4/R8 low byte after 33 clocks");
      read_expect(1'b1, 8'h01, "R4 high byte after 34 clocks");

      // R5/R11 interval timeout with N=5
      bus_write(1'b0, 8'h05);
      bus_write(1'b1, 8'h00);                 // n1: count 5
      read_expect(1'b0, 8'h05, "R2 interval load");      // n2
      read_expect(1'b1, 8'h00, "R3 high read");          // n3
      repeat (3) tick();                      // n6: count 0
      check({15'd0, flag}, 16'd0, "R5 flag not yet set at zero");
      read_expect(1'b0, 8'h00, "R11 low read at zero");  // coincides with timeout
      check({15'd0, flag}, 16'd1, "R11 set wins over read clear");
      check({15'd0, irq_n}, 16'd0, "R9 irq asserted when enabled");
      irq_en = 0;
      #1;
      check({15'd0, irq_n}, 16'd1, "R9 irq masked");
      check({15'd0, flag}, 16'd1, "R9 flag visible while masked");
      irq_en = 1;
      read_expect(1'b0, 8'hFF, "R5 rolled to FFFF");     // clears flag
      check({15'd0, flag}, 16'd0, "R3 low read clears flag");
      read_expect(1'b1, 8'hFF, "R5 keeps counting after wrap");
      stayed_low = 1'b1;
      for (int i = 0; i < 65600; i++) begin
         tick();
         if (flag !== 1'b0) stayed_low = 1'b0;
      end
      check({15'd0, stayed_low}, 16'd1, "R6 no second flag in interval mode");

      // pulse mode
      mode_pulse = 1;
      bus_write(1'b0, 8'h34);
      bus_write(1'b1, 8'h12);
      bus_write(1'b0, 8'h03);
      repeat (4) tick();
      read_expect(1'b0, 8'h34, "R1 latch write leaves counter");
      read_expect(1'b1, 8'h12, "R8 clock does not decrement in pulse mode");
      bus_write(1'b1, 8'h00);                 // count 0003
      pulse(); pulse();
      read_expect(1'b0, 8'h01, "R7 two pulses two steps");
      check({15'd0, flag}, 16'd0, "R7 no flag before zero");
      ext_pulse = 0;
      repeat (10) tick();
      check({15'd0, flag}, 16'd1, "R7 flag on reaching zero");
      check({15'd0, irq_n}, 16'd0, "R9 irq in pulse mode");
      read_expect(1'b1, 8'h00, "R7 long low gives one step");
      check({15'd0, flag}, 16'd1, "R3 high read leaves flag");
      ext_pulse = 1;
      repeat (3) tick();
      bus_write(1'b1, 8'h00);                 // reload 0003
      check({15'd0, flag}, 16'd0, "R2 high write clears flag");
      pulse(); pulse(); pulse();
      check({15'd0, flag}, 16'd1, "R2 rearmed after high write");
      read_expect(1'b0, 8'h00, "R7 count at zero");
      check({15'd0, flag}, 16'd0, "R3 low read clears flag (pulse)");
      pulse();
      read_expect(1'b1, 8'hFF, "R7 keeps counting past zero");
      check({15'd0, flag}, 16'd0, "R6 no second flag in pulse mode");
      check({15'd0, irq_n}, 16'd1, "R9 irq idle");

      repeat (2) tick();
      check(16'(exp_q.size()), 16'd0, "scoreboard drained");
      finish_run();
   end

endmodule